// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns pointer reports into five-byte serial mouse packets. A report carries signed 16-bit horizontal and vertical motion and three button flags, offered with a valid/ready handshake. For every accepted report the encoder pushes five bytes, one per clock, into a downstream byte FIFO. The host drains that FIFO at its own pace.

The first byte is a header in which each button appears as an active-low flag. The next two bytes are the horizontal and vertical motion, each clamped to a symmetric signed 8-bit range. The vertical motion has its sign flipped first, so that upward movement comes out positive. Two zero bytes close the packet.

A report is taken only while the encoder is idle and the FIFO reports room for a whole packet. A packet is therefore never split across a full FIFO.

Top module: `mouse_pkt_enc`

## Requirements
- R1: While and after reset, `pushEn` is low. With `fifoFree` of at least 5, `rptReady` is high once reset is released.
- R2: A report accepted at a rising clock edge (`rptValid` and `rptReady` both high) makes `pushEn` high for exactly the five following clock cycles. The bytes appear in the order header, X, Y, pad, pad.
- R3: The header byte is 0x87 with bits cleared for pressed buttons. `rptBtn[2]` (left) clears bit 2, `rptBtn[1]` (middle) clears bit 1 and `rptBtn[0]` (right) clears bit 0. A `rptBtn` bit of 1 means pressed.
- R4: The X byte is `rptDx`, read as signed, clamped to -127..+127 and sent in two's complement. -32768 yields 0x81.
- R5: The Y byte is the negation of `rptDy`, read as signed, clamped to -127..+127 and sent in two's complement. An input of -32768 yields 0x7F.
- R6: The fourth and fifth bytes of every packet are 0x00.
- R7: `rptReady` is low in every cycle in which `pushEn` is high.
- R8: `rptReady` is low while `fifoFree` is below 5. A report offered then is held without any push, and it is accepted once `fifoFree` reaches 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| rptValid | input | 1 | Report offered |
| rptReady | output | 1 | Encoder takes the report at this edge |
| rptDx | input | 16 | Horizontal motion, signed |
| rptDy | input | 16 | Vertical motion, signed |
| rptBtn | input | 3 | Buttons pressed: [2] left, [1] middle, [0] right |
| fifoFree | input | 6 | Number of free slots in the downstream FIFO |
| pushEn | output | 1 | Write strobe for the downstream FIFO |
| pushData | output | 8 | Byte to write |

## Verification
The bench drives motion values on and around the clamp limits, including the most negative 16-bit value on both axes. A design that clamped after truncation, or negated in 16 bits, would send a wrapped byte such as 0x00 or 0x80 instead of 0x81 or 0x7F. Button patterns are checked one at a time and all together, which exposes swapped bits or active-high flags. The bench holds a report while the FIFO has four free slots and checks that nothing is pushed. A design that tested for only one free slot would start a packet and later split it. Every packet is also checked for `rptReady` staying low during emission, for the five bytes running without a gap, and for `pushEn` dropping right after the fifth byte.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int BYTE_W   = 8;
  localparam int PKT_LEN  = 5;
  localparam int SAT_MAX  = (1 << (BYTE_W - 1)) - 1;
  localparam int BTN_N    = 3;
  localparam logic [BYTE_W-1:0] HDR_BASE = 8'h87;

  typedef struct packed {
    logic load;   // capture a new report into the byte slots
    logic shift;  // advance to the next byte of the packet
  } mpeStrobe_t;
endpackage

// File: rtl/mpe_datapath.sv
module mpe_datapath
  import mpe_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  mpeStrobe_t               strobe,
  input  logic [DW-1:0]            dx,
  input  logic [DW-1:0]            dy,
  input  logic [BTN_N-1:0]         btn,
  output logic [BYTE_W-1:0]        byteOut
);
  localparam int EW = DW + 1;
  localparam logic signed [EW-1:0] SAT_P = EW'(SAT_MAX);
  localparam logic signed [EW-1:0] SAT_N = -SAT_P;

  logic [DW-1:0]     axisIn [2];
  logic [BYTE_W-1:0] axisByte [2];
  logic [BYTE_W-1:0] hdrByte;
  logic [BYTE_W-1:0] slot [PKT_LEN];

  assign axisIn[0] = dx;
  assign axisIn[1] = dy;

  // Axis 0 passes through, axis 1 is negated; both clamp in DW+1 bits.
  for (genvar a = 0; a < 2; a++) begin : g_axis
    localparam bit NEG = (a == 1);
    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] val;
    always_comb begin
      ext = {axisIn[a][DW-1], axisIn[a]};
      val = NEG ? -ext : ext;
      if (val > SAT_P)      axisByte[a] = SAT_P[BYTE_W-1:0];
      else if (val < SAT_N) axisByte[a] = SAT_N[BYTE_W-1:0];
      else                  axisByte[a] = val[BYTE_W-1:0];
    end
  end

  // Header: button flags are active-low over a fixed pattern.
  for (genvar i = 0; i < BYTE_W; i++) begin : g_hdr
    if (i < BTN_N) begin : g_btn
      assign hdrByte[i] = HDR_BASE[i] & ~btn[i];
    end else begin : g_fix
      assign hdrByte[i] = HDR_BASE[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < PKT_LEN; k++) slot[k] <= '0;
    end else if (strobe.load) begin
      slot[0] <= hdrByte;
      slot[1] <= axisByte[0];
      slot[2] <= axisByte[1];
      for (int k = 3; k < PKT_LEN; k++) slot[k] <= '0;
    end else if (strobe.shift) begin
      for (int k = 0; k < PKT_LEN - 1; k++) slot[k] <= slot[k+1];
      slot[PKT_LEN-1] <= '0;
    end
  end

  assign byteOut = slot[0];
endmodule

// File: rtl/mpe_ctrl.sv
module mpe_ctrl
  import mpe_pkg::*;
#(
  parameter int FREE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rptValid,
  input  logic [FREE_W-1:0] fifoFree,
  output logic              rptReady,
  output logic              busy,
  output mpeStrobe_t        strobe
);
  localparam int CNT_W = $clog2(PKT_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_LEN - 1);

  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign rptReady = !busy && (fifoFree >= FREE_W'(PKT_LEN));
  assign accept   = rptValid && rptReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) busy <= 1'b0;
    end
  end

  always_comb begin
    strobe.load  = accept;
    strobe.shift = busy;
  end
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpe_pkg::*;
#(
  parameter int DW     = 16,
  parameter int FREE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rptValid,
  output logic              rptReady,
  input  logic [DW-1:0]     rptDx,
  input  logic [DW-1:0]     rptDy,
  input  logic [BTN_N-1:0]  rptBtn,
  input  logic [FREE_W-1:0] fifoFree,
  output logic              pushEn,
  output logic [BYTE_W-1:0] pushData
);
  mpeStrobe_t strobe;

  mpe_ctrl #(.FREE_W(FREE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rptValid(rptValid), .fifoFree(fifoFree),
    .rptReady(rptReady), .busy(pushEn), .strobe(strobe)
  );

  mpe_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dx(rptDx), .dy(rptDy),
    .btn(rptBtn), .byteOut(pushData)
  );
endmodule

// File: rtl/mpe_checker.sv
module mpe_checker
  import mpe_pkg::*;
#(
  parameter int DW     = 16,
  parameter int FREE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              rptValid,
  input logic              rptReady,
  input logic [DW-1:0]     rptDx,
  input logic [DW-1:0]     rptDy,
  input logic [BTN_N-1:0]  rptBtn,
  input logic [FREE_W-1:0] fifoFree,
  input logic              pushEn,
  input logic [BYTE_W-1:0] pushData
);
  logic [2:0] ckIdx;

  always_ff @(posedge clk) begin
    if (!rstN) ckIdx <= '0;
    else if (pushEn) ckIdx <= (ckIdx == 3'(PKT_LEN - 1)) ? '0 : ckIdx + 1'b1;
  end

  AST_NO_PUSH_AFTER_RESET: assert property (@(posedge clk) !rstN |=> !pushEn); // R1
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (rptValid && rptReady) |=> (pushEn && ckIdx == 3'd0)); // R2
  AST_RUN_UNBROKEN: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && ckIdx != 3'(PKT_LEN - 1)) |=> pushEn); // R2
  AST_HDR_FIXED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && ckIdx == 3'd0) |-> pushData[7:3] == 5'b10000); // R3
  AST_X_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && ckIdx == 3'd1) |-> pushData != 8'h80); // R4
  AST_Y_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && ckIdx == 3'd2) |-> pushData != 8'h80); // R5
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && ckIdx >= 3'd3) |-> pushData == 8'h00); // R6
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    pushEn |-> !rptReady); // R7
  AST_ROOM_FOR_PACKET: assert property (@(posedge clk) disable iff (!rstN)
    rptReady |-> fifoFree >= FREE_W'(PKT_LEN)); // R8
endmodule

bind mouse_pkt_enc mpe_checker #(.DW(DW), .FREE_W(FREE_W)) chk (.*);

// File: tb/mouse_pkt_enc_test.sv
`timescale 1ns/1ps
module mouse_pkt_enc_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rptValid = 1'b0;
  logic        rptReady;
  logic [15:0] rptDx = '0;
  logic [15:0] rptDy = '0;
  logic [2:0]  rptBtn = '0;
  logic [5:0]  fifoFree = 6'd32;
  logic        pushEn;
  logic [7:0]  pushData;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mouse_pkt_enc uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] clampByte(input int v);
    int c;
    c = (v > 127) ? 127 : ((v < -127) ? -127 : v);
    return c[7:0];
  endfunction

  // Drives one report, collects the packet and checks every byte.
  task automatic sendPkt(input logic [15:0] dx, input logic [15:0] dy, input logic [2:0] btn);
    logic [7:0] exp [5];
    exp[0] = 8'h87 ^ {5'b0, btn};
    exp[1] = clampByte($signed(dx));
    exp[2] = clampByte(-int'($signed(dy)));
    exp[3] = 8'h00;
    exp[4] = 8'h00;
    @(negedge clk);
    rptDx = dx; rptDy = dy; rptBtn = btn; rptValid = 1'b1;
    while (!rptReady) @(negedge clk);
    @(posedge clk);
    #1 rptValid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R2 push strobe", pushEn, 1'b1);
      check("R7 ready low while busy", rptReady, 1'b0);
      case (i)
        0: check("R3 header", pushData, exp[0]);
        1: check("R4 x byte", pushData, exp[1]);
        2: check("R5 y byte", pushData, exp[2]);
        default: check("R6 pad byte", pushData, 8'h00);
      endcase
    end
    @(negedge clk);
    check("R2 strobe ends after five", pushEn, 1'b0);
  endtask

  task automatic tReset();
    @(negedge clk);
    check("R1 no push in reset", pushEn, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 no push after reset", pushEn, 1'b0);
    check("R1 ready after reset", rptReady, 1'b1);
  endtask

  task automatic tBasic();
    sendPkt(16'd5, 16'd3, 3'b000);   // R2 87 05 FD 00 00
    sendPkt(16'hFFFE, 16'hFFF0, 3'b000);
  endtask

  task automatic tButtons();
    sendPkt(16'd0, 16'd0, 3'b100);   // R3 left
    sendPkt(16'd0, 16'd0, 3'b010);   // R3 middle
    sendPkt(16'd0, 16'd0, 3'b001);   // R3 right
    sendPkt(16'd1, 16'd1, 3'b111);   // R3 all
  endtask

  task automatic tClamp();
    sendPkt(16'd1000, 16'hFC18, 3'b000);  // R4 +1000, R5 -1000 -> 7F
    sendPkt(16'hFC18, 16'd1000, 3'b000);  // R4 -1000, R5 +1000 -> 81
    sendPkt(16'h8000, 16'h8000, 3'b000);  // R4 -32768 -> 81, R5 -> 7F
    sendPkt(16'h7FFF, 16'h7FFF, 3'b000);
    sendPkt(16'd127, 16'd127, 3'b000);
    sendPkt(16'hFF81, 16'hFF81, 3'b000);  // -127 both
    sendPkt(16'd128, 16'hFF80, 3'b000);   // one past the limit
    sendPkt(16'hFF80, 16'hFFFF, 3'b000);
  endtask

  task automatic tSpace();
    @(negedge clk);
    fifoFree = 6'd4;
    rptDx = 16'd9; rptDy = 16'd2; rptBtn = 3'b010; rptValid = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R8 ready low without room", rptReady, 1'b0);
      check("R8 no push without room", pushEn, 1'b0);
    end
    fifoFree = 6'd5;
    // The held report now goes through with the same fields.
    sendPkt(16'd9, 16'd2, 3'b010);
    fifoFree = 6'd32;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tReset();
    tBasic();
    tButtons();
    tClamp();
    tSpace();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule